// File: doc/BRIEF.md
# Processor Hotplug Presence and Event Status

This block keeps a presence bitmap with one bit per processor identifier and turns every processor plug or unplug into a general-purpose power-management event. Each bitmap byte can be read over a byte-wide register port. The event raises a level-sensitive system control interrupt once software has enabled it. Platform logic drives a plug or unplug pulse that carries the identifier. Firmware reads the bitmap to find out which processors are present, then acknowledges the event by writing a one to the status bit.

The register port decodes three regions. The first is a 32-byte presence window starting at 0xAF00. The second is a status byte at 0xAFE0. The third is an enable byte at 0xAFE4. The status byte also holds a second hotplug source, for PCI slots, which a separate input pulse sets. The interrupt output is registered.

Top module: `cpuhp_status`

## Requirements
- R1: After reset, presence bits for identifiers 0 to INIT_CPUS-1 (default 4) are 1 and all others are 0. The status byte, the enable byte and `sci_o` are all 0.
- R2: A read request to address 0xAF00+k returns window byte k on `rdata_o` one clock after the request. Bit (N mod 8) of byte (N div 8) holds the presence of identifier N.
- R3: A plug pulse sets the presence bit of `cpu_id_i`, and an unplug pulse clears it. When both arrive in the same cycle, the plug takes effect.
- R4: Every accepted plug or unplug sets status bit 2 (mask 0x04) in the same clock edge that updates the bitmap.
- R5: An identifier of 256 or above is rejected. It changes no presence bit and sets no status bit.
- R6: Writes to the presence window leave the bitmap unchanged.
- R7: Writing 0xAFE0 clears each status bit (bits 1 and 2) where the write data holds a 1. Writing 0xAFE4 loads the enable byte. Both bytes read back at their addresses, and unused status bits read 0.
- R8: When a processor event and a write that clears bit 2 land in the same cycle, bit 2 ends up set.
- R9: `sci_o` is high when (status AND enable) has bit 1 or bit 2 set, as computed from the register values of the previous clock.
- R10: A `pci_evt_i` pulse sets status bit 1 (mask 0x02).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid one clock after a read request |
| plug_i | input | 1 | Processor plug pulse |
| unplug_i | input | 1 | Processor unplug pulse |
| cpu_id_i | input | ID_W | Identifier for the plug or unplug pulse |
| pci_evt_i | input | 1 | PCI hotplug event pulse |
| sci_o | output | 1 | Level interrupt to the platform |

## Verification
The bench reads the window bytes that hold the changed identifiers after each event. This catches a design that decodes the wrong byte or bit, and one that lets the unplug win when both pulses arrive together. Identifiers of 256 and 300 are sent to show that an alias would wrongly set or clear bits in low bytes. A write-one-to-clear is issued in the same cycle as an event, where a design that lets the clear win would lose the acknowledgement. The interrupt is sampled one clock after each status and enable change, using several enable patterns, to catch an early, late or wrongly masked level.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;
  localparam int unsigned PCI_BIT = 1;
  localparam int unsigned CPU_BIT = 2;
  localparam logic [7:0]  SCI_MASK = 8'h06;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_WIN,
    SEL_STS,
    SEL_EN
  } sel_e;
endpackage

// File: rtl/cpuhp_decode.sv
module cpuhp_decode
  import cpuhp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BASE  = 32'hAF00,
  parameter int unsigned WIN_BYTES = 32,
  parameter int unsigned STS_ADDR  = 32'hAFE0,
  parameter int unsigned EN_ADDR   = 32'hAFE4,
  localparam int unsigned OFF_W    = $clog2(WIN_BYTES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o,
  output logic [OFF_W-1:0]  off_o
);
  logic [31:0] a;
  assign a = 32'(addr_i);

  always_comb begin
    off_o = OFF_W'(a - WIN_BASE);
    if (a >= WIN_BASE && a < WIN_BASE + WIN_BYTES) sel_o = SEL_WIN;
    else if (a == STS_ADDR)                        sel_o = SEL_STS;
    else if (a == EN_ADDR)                         sel_o = SEL_EN;
    else                                           sel_o = SEL_NONE;
  end
endmodule

// File: rtl/cpuhp_presence.sv
module cpuhp_presence #(
  parameter int unsigned WIN_BYTES = 32,
  parameter int unsigned ID_W      = 9,
  parameter int unsigned INIT_CPUS = 4,
  localparam int unsigned NBITS    = WIN_BYTES * 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             plug_i,
  input  logic             unplug_i,
  input  logic [ID_W-1:0]  id_i,
  output logic [NBITS-1:0] pres_o,
  output logic             accept_o
);
  logic id_ok;
  assign id_ok    = 32'(id_i) < NBITS;
  assign accept_o = (plug_i || unplug_i) && id_ok;

  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    localparam logic RST_V = (g < INIT_CPUS);
    logic hit;
    assign hit = id_ok && (32'(id_i) == g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              pres_o[g] <= RST_V;
      else if (hit && plug_i)   pres_o[g] <= 1'b1;  // plug has priority
      else if (hit && unplug_i) pres_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/cpuhp_gpe.sv
module cpuhp_gpe
  import cpuhp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cpu_evt_i,
  input  logic       pci_evt_i,
  input  logic       sts_wr_i,
  input  logic       en_wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] sts_o,
  output logic [7:0] en_o,
  output logic       sci_o
);
  logic pci_q, cpu_q;

  // set beats write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pci_q <= 1'b0;
      cpu_q <= 1'b0;
    end else begin
      pci_q <= pci_evt_i || (pci_q && !(sts_wr_i && wdata_i[PCI_BIT]));
      cpu_q <= cpu_evt_i || (cpu_q && !(sts_wr_i && wdata_i[CPU_BIT]));
    end
  end

  always_comb begin
    sts_o          = '0;
    sts_o[PCI_BIT] = pci_q;
    sts_o[CPU_BIT] = cpu_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (en_wr_i) en_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sci_o <= 1'b0;
    else         sci_o <= |(sts_o & en_o & SCI_MASK);
  end
endmodule

// File: rtl/cpuhp_status.sv
module cpuhp_status
  import cpuhp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BASE  = 32'hAF00,
  parameter int unsigned WIN_BYTES = 32,
  parameter int unsigned STS_ADDR  = 32'hAFE0,
  parameter int unsigned EN_ADDR   = 32'hAFE4,
  parameter int unsigned ID_W      = 9,
  parameter int unsigned INIT_CPUS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              plug_i,
  input  logic              unplug_i,
  input  logic [ID_W-1:0]   cpu_id_i,
  input  logic              pci_evt_i,
  output logic              sci_o
);
  localparam int unsigned OFF_W = $clog2(WIN_BYTES);
  localparam int unsigned NBITS = WIN_BYTES * 8;

  sel_e             sel;
  logic [OFF_W-1:0] off;
  logic [NBITS-1:0] pres_q;
  logic             cpu_evt;
  logic [7:0]       sts_q, en_q, rd_next;
  logic             sts_wr, en_wr;

  cpuhp_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
    .STS_ADDR(STS_ADDR), .EN_ADDR(EN_ADDR)
  ) u_dec (
    .addr_i(addr_i), .sel_o(sel), .off_o(off)
  );

  cpuhp_presence #(
    .WIN_BYTES(WIN_BYTES), .ID_W(ID_W), .INIT_CPUS(INIT_CPUS)
  ) u_pres (
    .clk_i(clk_i), .rst_ni(rst_ni), .plug_i(plug_i), .unplug_i(unplug_i),
    .id_i(cpu_id_i), .pres_o(pres_q), .accept_o(cpu_evt)
  );

  assign sts_wr = req_i && we_i && (sel == SEL_STS);
  assign en_wr  = req_i && we_i && (sel == SEL_EN);

  cpuhp_gpe u_gpe (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpu_evt_i(cpu_evt), .pci_evt_i(pci_evt_i),
    .sts_wr_i(sts_wr), .en_wr_i(en_wr), .wdata_i(wdata_i),
    .sts_o(sts_q), .en_o(en_q), .sci_o(sci_o)
  );

  // window writes are dropped: no write path into the bitmap
  always_comb begin
    unique case (sel)
      SEL_WIN: rd_next = pres_q[{off, 3'b000} +: 8];
      SEL_STS: rd_next = sts_q;
      SEL_EN:  rd_next = en_q;
      default: rd_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= 8'h00;
    else if (req_i && !we_i)  rdata_o <= rd_next;
  end
endmodule

// File: rtl/cpuhp_status_chk.sv
module cpuhp_status_chk #(
  parameter int unsigned WIN_BYTES = 32,
  parameter int unsigned ID_W      = 9,
  localparam int unsigned NBITS    = WIN_BYTES * 8,
  localparam int unsigned IDX_W    = $clog2(NBITS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             plug_i,
  input logic             unplug_i,
  input logic [ID_W-1:0]  cpu_id_i,
  input logic [NBITS-1:0] pres_q,
  input logic [7:0]       sts_q,
  input logic [7:0]       en_q,
  input logic             sci_o
);
  logic             vld;
  logic [IDX_W-1:0] idx;
  assign vld = 32'(cpu_id_i) < NBITS;
  assign idx = cpu_id_i[IDX_W-1:0];

  p_plug_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plug_i && vld |=> pres_q[$past(idx)]);

  p_unplug_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unplug_i && !plug_i && vld |=> !pres_q[$past(idx)]);

  p_evt_sets_sts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plug_i || unplug_i) && vld |=> sts_q[2]);

  p_reject_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plug_i || unplug_i) && !vld |=> $stable(pres_q));

  p_pres_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(plug_i || unplug_i) |=> $stable(pres_q));

  p_sci_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sci_o == (($past(sts_q) & $past(en_q) & 8'h06) != 8'h00)));
endmodule

bind cpuhp_status cpuhp_status_chk #(
  .WIN_BYTES(WIN_BYTES), .ID_W(ID_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .plug_i(plug_i), .unplug_i(unplug_i),
  .cpu_id_i(cpu_id_i), .pres_q(pres_q), .sts_q(sts_q), .en_q(en_q),
  .sci_o(sci_o)
);

// File: tb/cpuhp_status_tb.sv
`timescale 1ns/1ps
module cpuhp_status_tb;
  localparam int WIN  = 32'hAF00;
  localparam int STS  = 32'hAFE0;
  localparam int EN   = 32'hAFE4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req = 0, we = 0, plug = 0, unplug = 0, pci = 0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [8:0]  cpu_id = '0;
  logic [7:0]  rdata;
  logic        sci;

  cpuhp_status u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .plug_i(plug), .unplug_i(unplug),
    .cpu_id_i(cpu_id), .pci_evt_i(pci), .sci_o(sci)
  );

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sbq[$];
  int checks = 0, errors = 0;
  bit done = 0;
  bit mdl [256];
  logic [7:0] msts = 0, men = 0;
  logic rd_seen = 0;

  always @(posedge clk) rd_seen <= req && !we;

  // monitor: compares read data against the scoreboard
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected read data %02h expected none", rdata);
      end else begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (rdata !== it.exp) begin
          errors++;
          $display("FAIL %s read %02h expected %02h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  function automatic logic [7:0] mbyte(int b);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = mdl[b*8+i];
    return v;
  endfunction

  task automatic rd(int a, logic [7:0] e, string tag);
    @(negedge clk);
    req = 1; we = 0; addr = 16'(a);
    sbq.push_back('{e, tag});
    @(negedge clk);
    req = 0;
  endtask

  task automatic rdw(int b, string tag);
    rd(WIN + b, mbyte(b), tag);
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = 16'(a); wdata = d;
    if (a == STS) msts = msts & ~(d & 8'h06);
    if (a == EN)  men = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic evt(bit p, bit u, int id, bit clr);
    @(negedge clk);
    plug = p; unplug = u; cpu_id = 9'(id);
    if (clr) begin req = 1; we = 1; addr = 16'(STS); wdata = 8'h04; msts[2] = 1'b0; end
    if (id < 256 && (p || u)) begin
      mdl[id] = p;
      msts[2] = 1'b1;
    end
    @(negedge clk);
    plug = 0; unplug = 0; req = 0; we = 0;
  endtask

  task automatic pci_evt();
    @(negedge clk);
    pci = 1; msts[1] = 1'b1;
    @(negedge clk);
    pci = 0;
  endtask

  task automatic chk_sci(string tag);
    logic e;
    @(negedge clk);
    e = |(msts & men & 8'h06);
    checks++;
    if (sci !== e) begin
      errors++;
      $display("FAIL %s sci %0b expected %0b", tag, sci, e);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = (i < 4);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int b = 0; b < 32; b++) rdw(b, "R1 reset window");
    rd(STS, 8'h00, "R1 reset status");
    rd(EN, 8'h00, "R1 reset enable");
    chk_sci("R1 reset sci");

    // R3/R4: plug id 9, status bit 2 set, masked sci stays low
    evt(1, 0, 9, 0);
    rdw(1, "R3 plug id 9");
    rd(STS, msts, "R4 status after plug");
    chk_sci("R9 masked sci");

    // R7/R9: enable cpu bit
    wr(EN, 8'h04);
    rd(EN, 8'h04, "R7 enable readback");
    chk_sci("R9 sci after enable");

    // R7: w1c clears bit 2, sci falls
    wr(STS, 8'h04);
    rd(STS, msts, "R7 w1c status");
    chk_sci("R9 sci after clear");

    // R3: unplug id 2, high id 255
    evt(0, 1, 2, 0);
    rdw(0, "R3 unplug id 2");
    rd(STS, msts, "R4 status after unplug");
    chk_sci("R9 sci after unplug");
    evt(1, 0, 255, 0);
    rdw(31, "R2 plug id 255 byte 31");

    // R3: both pulses same cycle, plug wins
    evt(1, 1, 100, 0);
    rdw(12, "R3 plug beats unplug");

    // R5: out-of-range ids rejected
    wr(STS, 8'h06);
    evt(1, 0, 300, 0);
    evt(0, 1, 256, 0);
    rd(STS, msts, "R5 reject no status");
    rdw(5, "R5 reject no alias set");
    rdw(0, "R5 reject no alias clear");

    // R6: window write ignored
    wr(WIN, 8'h00);
    wr(WIN + 31, 8'hFF);
    rdw(0, "R6 window write byte 0");
    rdw(31, "R6 window write byte 31");

    // R8: event beats same-cycle clear
    evt(1, 0, 20, 1);
    rd(STS, msts, "R8 event beats clear");
    rdw(2, "R8 plug id 20");

    // R10/R9: pci source
    wr(STS, 8'h04);
    wr(EN, 8'h02);
    chk_sci("R9 sci idle");
    pci_evt();
    rd(STS, msts, "R10 pci status bit");
    chk_sci("R10 sci from pci");
    wr(EN, 8'h00);
    chk_sci("R9 sci disabled");

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule